// File: doc/BRIEF.md
# Vectored Interrupt Request and In-Service Tracker

This block keeps the bookkeeping for up to 256 interrupt vectors. It holds three bit-vectors with one bit per vector. The pending vector records requests that have been accepted but not yet handed to the core. The in-service vector records requests the core is handling. The trigger vector records the trigger mode that came with each accepted request. A vector's number is its priority, and the larger number wins. The top four bits of the vector form its priority class.

An accept port records a request. An interrupt-request output tells the core when a pending vector may be dispatched, and a combinational output presents that vector. The core takes it with a one-cycle ready pulse. In that cycle the vector's pending bit moves into the in-service register. An end-of-interrupt strobe retires the highest in-service vector. A higher-class request may nest over the one being serviced when core interrupts are enabled. A read port returns any 32-bit word of any of the three registers.

Top module: `irq_vec_tracker`

## Requirements
- R1: After reset all three registers are zero, and `irq_req` is low.
- R2: Vectors 0 to 15 are reserved. Accepting one sets no bit, and bits 0 to 15 of every register always read zero.
- R3: An accept of vector v (v >= 16) sets pending bit v. In the same cycle it writes trigger bit v with `acc_trig`, replacing any earlier value.
- R4: A ready pulse while `irq_req` is high clears the highest set pending bit and sets the same in-service bit. `disp_vec` shows that vector during the pulse.
- R5: An `eoi` pulse clears the highest set in-service bit. The next dispatch then takes the highest pending vector that remains.
- R6: A vector can be pending and in service at the same time. Repeated accepts of a vector that is already pending leave a single pending bit, so one dispatch empties it.
- R7: `irq_req` is high when a pending vector exists and either nothing is in service, or `core_ie` is high and the pending class (bits 7:4) is strictly greater than the class of the highest in-service vector. An equal class never nests.
- R8: A nested dispatch leaves the interrupted vector in service. Its end-of-interrupt retires only the nested vector, and the interrupted vector is then the highest in-service vector again.
- R9: If an accept and a dispatch name the same vector in the same cycle, that vector ends up both in service and pending.
- R10: `rd_data` returns bits 32n+31..32n of the register chosen by `rd_sel`, where n is `rd_word` (0..7). The selector codes are: 0 for pending, 1 for in-service, 2 for trigger, and 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Accept strobe for one request |
| acc_vec | input | 8 | Vector being accepted |
| acc_trig | input | 1 | Trigger mode of the accepted request |
| core_ie | input | 1 | Core interrupt enable; gates nesting |
| core_rdy | input | 1 | One-cycle acknowledge from the core |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_req | output | 1 | A dispatchable pending vector exists |
| disp_vec | output | 8 | Highest pending vector, which is the one a ready pulse dispatches |
| rd_sel | input | 2 | Register select for the read port |
| rd_word | input | 3 | Word index for the read port |
| rd_data | output | 32 | Selected 32-bit word |

## Verification
The bench targets the points where a faulty tracker would lose or duplicate work:
- A reserved vector that leaked into the registers would show up as a nonzero low word.
- A duplicate that was counted twice would still leave a pending bit after one dispatch.
- A wrong nesting rule would raise `irq_req` for a request in the same class, or with `core_ie` low.
- An end-of-interrupt that cleared the wrong bit would drop the interrupted vector after a nested one retires.
- A dispatch that cleared pending after the accept in the same cycle would lose the request that arrived in that cycle.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_INSV = 2'd1,
        SEL_TRIG = 2'd2,
        SEL_NONE = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/irq_trk_prienc.sv
module irq_trk_prienc #(
    parameter int N = 256,
    parameter int W = 8
) (
    input  logic [N-1:0] bits,
    output logic [W-1:0] idx,
    output logic         valid
);
    // Ascending scan: the last set bit found is the highest one.
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                idx   = W'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_trk_readmux.sv
module irq_trk_readmux
    import irq_trk_pkg::*;
#(
    parameter int N      = 256,
    parameter int WORD_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic [N-1:0]      pend,
    input  logic [N-1:0]      insv,
    input  logic [N-1:0]      trig,
    input  logic [1:0]        sel,
    input  logic [SEL_W-1:0]  word,
    output logic [WORD_W-1:0] data
);
    logic [N-1:0] chosen;

    always_comb begin
        case (rd_sel_e'(sel))
            SEL_PEND: chosen = pend;
            SEL_INSV: chosen = insv;
            SEL_TRIG: chosen = trig;
            default:  chosen = '0;
        endcase
        data = chosen[word*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/irq_vec_tracker.sv
module irq_vec_tracker #(
    parameter int VEC_W  = 8,
    parameter int RSVD   = 16,
    parameter int CLS_W  = 4,
    parameter int WORD_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             acc_valid,
    input  logic [VEC_W-1:0]                 acc_vec,
    input  logic                             acc_trig,
    input  logic                             core_ie,
    input  logic                             core_rdy,
    input  logic                             eoi,
    output logic                             irq_req,
    output logic [VEC_W-1:0]                 disp_vec,
    input  logic [1:0]                       rd_sel,
    input  logic [$clog2((1<<VEC_W)/WORD_W)-1:0] rd_word,
    output logic [WORD_W-1:0]                rd_data
);
    localparam int NVEC  = 1 << VEC_W;
    localparam int NWORD = NVEC / WORD_W;
    localparam int WSEL  = $clog2(NWORD);

    typedef struct packed {
        logic [NVEC-1:0] pend;
        logic [NVEC-1:0] insv;
        logic [NVEC-1:0] trig;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic [NVEC-1:0]  pend_v, insv_v, trig_v;
    logic [VEC_W-1:0] pend_hi, ins_hi;
    logic             pend_valid, ins_valid;
    logic             acc_ok, dispatch;

    assign pend_v = st_q.pend;
    assign insv_v = st_q.insv;
    assign trig_v = st_q.trig;

    irq_trk_prienc #(.N(NVEC), .W(VEC_W)) u_pend_enc (
        .bits(pend_v), .idx(pend_hi), .valid(pend_valid)
    );

    irq_trk_prienc #(.N(NVEC), .W(VEC_W)) u_insv_enc (
        .bits(insv_v), .idx(ins_hi), .valid(ins_valid)
    );

    assign irq_req  = pend_valid &&
                      (!ins_valid ||
                       (core_ie && (pend_hi[VEC_W-1 -: CLS_W] > ins_hi[VEC_W-1 -: CLS_W])));
    assign disp_vec = pend_hi;
    assign acc_ok   = acc_valid && (acc_vec >= VEC_W'(RSVD));
    assign dispatch = core_rdy && irq_req;

    // Order matters: retire, then dispatch, then accept, so that an
    // arrival in a dispatch cycle stays queued behind the dispatched one.
    always_comb begin
        st_d = st_q;
        if (eoi && ins_valid) begin
            st_d.insv[ins_hi] = 1'b0;
        end
        if (dispatch) begin
            st_d.pend[pend_hi] = 1'b0;
            st_d.insv[pend_hi] = 1'b1;
        end
        if (acc_ok) begin
            st_d.pend[acc_vec] = 1'b1;
            st_d.trig[acc_vec] = acc_trig;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    irq_trk_readmux #(.N(NVEC), .WORD_W(WORD_W), .SEL_W(WSEL)) u_rd (
        .pend(pend_v), .insv(insv_v), .trig(trig_v),
        .sel(rd_sel), .word(rd_word), .data(rd_data)
    );
endmodule

// File: rtl/irq_trk_chk.sv
module irq_trk_chk #(
    parameter int VEC_W = 8,
    parameter int RSVD  = 16,
    parameter int CLS_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_valid,
    input logic [VEC_W-1:0]        acc_vec,
    input logic                    acc_trig,
    input logic                    core_ie,
    input logic                    core_rdy,
    input logic                    eoi,
    input logic                    irq_req,
    input logic [VEC_W-1:0]        disp_vec,
    input logic [(1<<VEC_W)-1:0]   pend,
    input logic [(1<<VEC_W)-1:0]   insv,
    input logic [(1<<VEC_W)-1:0]   trig,
    input logic [VEC_W-1:0]        ins_hi,
    input logic                    ins_valid
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[RSVD-1:0] == '0) && (insv[RSVD-1:0] == '0) && (trig[RSVD-1:0] == '0));

    assert_accept_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_vec >= VEC_W'(RSVD))) |=>
        (pend[$past(acc_vec)] && (trig[$past(acc_vec)] == $past(acc_trig))));

    assert_dispatch_insv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rdy && irq_req) |=> insv[$past(disp_vec)]);

    assert_eoi_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && ins_valid && !(core_rdy && irq_req && (disp_vec == ins_hi))) |=>
        !insv[$past(ins_hi)]);

    assert_nest_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ins_valid) |->
        (core_ie && (disp_vec[VEC_W-1 -: CLS_W] > ins_hi[VEC_W-1 -: CLS_W])));
endmodule

bind irq_vec_tracker irq_trk_chk #(.VEC_W(VEC_W), .RSVD(RSVD), .CLS_W(CLS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vec(acc_vec),
    .acc_trig(acc_trig), .core_ie(core_ie), .core_rdy(core_rdy), .eoi(eoi),
    .irq_req(irq_req), .disp_vec(disp_vec), .pend(pend_v), .insv(insv_v),
    .trig(trig_v), .ins_hi(ins_hi), .ins_valid(ins_valid)
);

// File: tb/tb_irq_vec_tracker.sv
module tb_irq_vec_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [7:0]  acc_vec = '0;
    logic        acc_trig = 1'b0;
    logic        core_ie = 1'b0;
    logic        core_rdy = 1'b0;
    logic        eoi = 1'b0;
    logic        irq_req;
    logic [7:0]  disp_vec;
    logic [1:0]  rd_sel = '0;
    logic [2:0]  rd_word = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    irq_vec_tracker dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vec(acc_vec),
        .acc_trig(acc_trig), .core_ie(core_ie), .core_rdy(core_rdy), .eoi(eoi),
        .irq_req(irq_req), .disp_vec(disp_vec), .rd_sel(rd_sel),
        .rd_word(rd_word), .rd_data(rd_data)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [1:0] s, input logic [2:0] w,
                          input logic [31:0] exp);
        rd_sel  = s;
        rd_word = w;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic accept(input logic [7:0] v, input logic t);
        acc_valid = 1'b1; acc_vec = v; acc_trig = t;
        tick();
        acc_valid = 1'b0;
    endtask

    // Driver: queue the expected vector, then pulse ready.
    task automatic dispatch(input logic [7:0] v);
        exp_q.push_back(v);
        core_rdy = 1'b1;
        tick();
        core_rdy = 1'b0;
    endtask

    task automatic retire();
        eoi = 1'b1;
        tick();
        eoi = 1'b0;
    endtask

    // Monitor: compares the presented vector while ready is high.
    always @(negedge clk) begin
        if (rst_n && core_rdy) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected dispatch", 32'(disp_vec), 32'hffff_ffff);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk("R4 dispatched vector", 32'(disp_vec), 32'(e));
                chk("R7 irq_req at dispatch", 32'(irq_req), 32'd1);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        for (int w = 0; w < 8; w++) begin
            chk_rd("R1 pend reset", 2'd0, 3'(w), 32'h0);
            chk_rd("R1 insv reset", 2'd1, 3'(w), 32'h0);
            chk_rd("R1 trig reset", 2'd2, 3'(w), 32'h0);
        end
        chk("R1 irq_req reset", 32'(irq_req), 32'd0);

        // R2 reserved vector ignored
        accept(8'h05, 1'b1);
        chk_rd("R2 pend word0", 2'd0, 3'd0, 32'h0);
        chk_rd("R2 trig word0", 2'd2, 3'd0, 32'h0);
        chk("R2 irq_req", 32'(irq_req), 32'd0);

        // R3 accept, R10 word position
        accept(8'h40, 1'b1);
        chk_rd("R3 pend bit 0x40", 2'd0, 3'd2, 32'h1);
        chk_rd("R3 trig bit 0x40", 2'd2, 3'd2, 32'h1);
        chk_rd("R10 unused select", 2'd3, 3'd2, 32'h0);
        chk("R7 irq idle service", 32'(irq_req), 32'd1);
        accept(8'h22, 1'b0);
        chk_rd("R10 pend word1", 2'd0, 3'd1, 32'h4);
        chk("R4 highest shown", 32'(disp_vec), 32'h40);

        dispatch(8'h40);
        chk_rd("R4 pend cleared", 2'd0, 3'd2, 32'h0);
        chk_rd("R4 insv set", 2'd1, 3'd2, 32'h1);
        chk("R7 lower class blocked", 32'(irq_req), 32'd0);

        // R6 pending and in service together, duplicates collapse
        accept(8'h40, 1'b1);
        accept(8'h40, 1'b1);
        chk_rd("R6 pend again", 2'd0, 3'd2, 32'h1);
        chk_rd("R6 still in service", 2'd1, 3'd2, 32'h1);
        retire();
        chk_rd("R5 insv retired", 2'd1, 3'd2, 32'h0);
        dispatch(8'h40);
        chk_rd("R6 single pending", 2'd0, 3'd2, 32'h0);
        retire();
        dispatch(8'h22);
        chk_rd("R5 next dispatched", 2'd1, 3'd1, 32'h4);

        // R7/R8 nesting
        accept(8'h95, 1'b0);
        chk("R7 ie low blocks", 32'(irq_req), 32'd0);
        core_ie = 1'b1;
        #1;
        chk("R7 ie high nests", 32'(irq_req), 32'd1);
        dispatch(8'h95);
        chk_rd("R8 nested insv", 2'd1, 3'd4, 32'h0020_0000);
        chk_rd("R8 outer kept", 2'd1, 3'd1, 32'h4);
        retire();
        chk_rd("R8 nested retired", 2'd1, 3'd4, 32'h0);
        chk_rd("R8 outer resumes", 2'd1, 3'd1, 32'h4);
        accept(8'h25, 1'b0);
        chk("R7 equal class blocked", 32'(irq_req), 32'd0);
        retire();
        chk("R7 after retire", 32'(irq_req), 32'd1);

        // R9 same-cycle accept and dispatch of one vector
        acc_valid = 1'b1; acc_vec = 8'h25; acc_trig = 1'b1;
        dispatch(8'h25);
        acc_valid = 1'b0;
        chk_rd("R9 pend kept", 2'd0, 3'd1, 32'h20);
        chk_rd("R9 insv set", 2'd1, 3'd1, 32'h20);

        // R3 trigger overwrite
        accept(8'hFF, 1'b1);
        chk_rd("R3 trig set", 2'd2, 3'd7, 32'h8000_0000);
        accept(8'hFF, 1'b0);
        chk_rd("R3 trig cleared", 2'd2, 3'd7, 32'h0);
        chk_rd("R10 pend word7", 2'd0, 3'd7, 32'h8000_0000);

        tick();
        chk("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule